// File: doc/BRIEF.md
# Additive Write Delay Splitter

This block turns a signed per-rank timing adjustment, given in whole clock cycles, into the two forms that the write path can apply. The coarse form is a 2-bit additive-delay count placed in the addressed rank's slot of a shared delay word. The fine form is a signed residual in phase-interpolator ticks, at 128 ticks per cycle. Calibration logic applies the residual to every lane of that rank.

The coarse count saturates at 2 cycles. Any part of the target above that, and the whole of a negative target, goes into the residual. A one-cycle strobe carries a rank index and a target. On the next clock edge the block rewrites only that rank's slot and presents the matching residual, with a valid flag that stays high for one cycle.

Top module: `addDelaySplitter`

## Requirements
- R1: After reset the delay word is 0, the residual is 0 and the valid flag is low.
- R2: A target from 0 to 2 inclusive writes the target into the addressed slot and gives a residual of 0.
- R3: A target greater than 2 writes 2 into the addressed slot and gives a residual of 128*(target-2). A slot never holds 3.
- R4: A negative target writes 0 into the addressed slot and gives a residual of 128*target, which is negative.
- R5: Rank r owns bits [2r+1:2r] of the delay word. A strobe for one rank leaves the other three slots unchanged.
- R6: The delay word and the residual take their new values on the first clock edge after the strobe. The valid flag is high for exactly that one cycle.
- R7: With the strobe low, the delay word and the residual keep their values and the valid flag is low, whatever the rank and target inputs do.
- R8: The extreme targets give exact 16-bit residuals: -128 gives -16384 and +127 gives 16000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| loadStrobe | input | 1 | One-cycle request to split a target |
| rankSel | input | 2 | Rank whose slot is updated |
| targetOffset | input | 8 | Signed target offset in cycles |
| delayWord | output | 8 | Shared additive-delay word, 2 bits per rank |
| residual | output | 16 | Signed residual phase offset in ticks |
| residualValid | output | 1 | High for the one cycle after a strobe |

## Verification
A wrong slot update shows in the delay word on the edge after the strobe. It can appear as a neighbour's bits changing, or as a saturated field reading 3 or a negative target leaving a nonzero count. A fault in the split arithmetic shows in the residual in the same cycle, so every scenario checks the word and the residual together one cycle after its strobe. Hold faults only show on a later strobe-free cycle, so the bench also drives the rank and target inputs with the strobe low and rechecks both outputs.

// File: rtl/adsPkg.sv
package adsPkg;
  localparam int CTRL_RANK_W = 8;

  typedef struct packed {
    logic                   load;
    logic [CTRL_RANK_W-1:0] rank;
  } ctrlStrobes_t;
endpackage

// File: rtl/adsCtrl.sv
module adsCtrl
  import adsPkg::*;
#(
  parameter int RANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadStrobe,
  input  logic [RANK_W-1:0] rankSel,
  output ctrlStrobes_t      ctl,
  output logic              validOut
);
  always_comb begin
    ctl.load = loadStrobe;
    ctl.rank = CTRL_RANK_W'(rankSel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) validOut <= 1'b0;
    else       validOut <= loadStrobe;
  end

  // R6: valid follows exactly one cycle after a strobe
  assert_valid_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    loadStrobe |=> validOut);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    !loadStrobe |=> !validOut);
endmodule

// File: rtl/adsDatapath.sv
module adsDatapath
  import adsPkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int FIELD_W       = 2,
  parameter int MAX_CYC       = 2,
  parameter int TICKS_PER_CYC = 128,
  parameter int OFFSET_W      = 8,
  parameter int RESID_W       = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrobes_t                 ctl,
  input  logic signed [OFFSET_W-1:0]   targetOffset,
  output logic [NUM_RANKS*FIELD_W-1:0] delayWord,
  output logic signed [RESID_W-1:0]    residual
);
  localparam int WORD_W     = NUM_RANKS * FIELD_W;
  localparam int TICK_SHIFT = $clog2(TICKS_PER_CYC);
  localparam int EXT_W      = OFFSET_W + 1;
  localparam logic signed [EXT_W-1:0] maxCycS = EXT_W'(MAX_CYC);

  logic signed [EXT_W-1:0]   tgtExt;
  logic signed [EXT_W-1:0]   excess;
  logic [FIELD_W-1:0]        fieldNext;
  logic signed [RESID_W-1:0] excessWide;
  logic signed [RESID_W-1:0] residNext;
  logic [WORD_W-1:0]         wordNext;

  always_comb begin
    tgtExt = {targetOffset[OFFSET_W-1], targetOffset};
    if (tgtExt > maxCycS) begin
      fieldNext = FIELD_W'(MAX_CYC);
      excess    = tgtExt - maxCycS;
    end else if (tgtExt < 0) begin
      fieldNext = '0;
      excess    = tgtExt;
    end else begin
      fieldNext = tgtExt[FIELD_W-1:0];
      excess    = '0;
    end
    excessWide = {{(RESID_W-EXT_W){excess[EXT_W-1]}}, excess};
    residNext  = excessWide <<< TICK_SHIFT;
  end

  always_comb begin
    wordNext = delayWord;
    for (int i = 0; i < NUM_RANKS; i++) begin
      if (ctl.load && (ctl.rank == CTRL_RANK_W'(i)))
        wordNext[i*FIELD_W +: FIELD_W] = fieldNext;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      delayWord <= '0;
      residual  <= '0;
    end else if (ctl.load) begin
      delayWord <= wordNext;
      residual  <= residNext;
    end
  end

  // R7: no strobe, no change
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.load |=> ($stable(delayWord) && $stable(residual)));
  // R4: negative target gives negative residual
  assert_neg_resid_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && targetOffset < 0) |=> residual < 0);
  // R3: above-limit target gives positive residual
  assert_pos_resid_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && tgtExt > maxCycS) |=> residual > 0);
  // R2: in-range target gives zero residual
  assert_zero_resid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && tgtExt >= 0 && tgtExt <= maxCycS) |=> residual == 0);

  for (genvar r = 0; r < NUM_RANKS; r++) begin : gSlotChk
    // R3: saturated field never exceeds the limit
    assert_slot_max_R3: assert property (@(posedge clk) disable iff (!rstN)
      delayWord[r*FIELD_W +: FIELD_W] <= FIELD_W'(MAX_CYC));
    // R5: other ranks untouched
    assert_other_slot_R5: assert property (@(posedge clk) disable iff (!rstN)
      (ctl.load && ctl.rank != CTRL_RANK_W'(r)) |=> $stable(delayWord[r*FIELD_W +: FIELD_W]));
  end
endmodule

// File: rtl/addDelaySplitter.sv
module addDelaySplitter
  import adsPkg::*;
#(
  parameter int NUM_RANKS     = 4,
  parameter int FIELD_W       = 2,
  parameter int MAX_CYC       = 2,
  parameter int TICKS_PER_CYC = 128,
  parameter int OFFSET_W      = 8,
  parameter int RESID_W       = 16,
  localparam int RANK_W       = $clog2(NUM_RANKS),
  localparam int WORD_W       = NUM_RANKS * FIELD_W
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadStrobe,
  input  logic [RANK_W-1:0]          rankSel,
  input  logic signed [OFFSET_W-1:0] targetOffset,
  output logic [WORD_W-1:0]          delayWord,
  output logic signed [RESID_W-1:0]  residual,
  output logic                       residualValid
);
  ctrlStrobes_t ctl;

  adsCtrl #(.RANK_W(RANK_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .rankSel(rankSel),
    .ctl(ctl), .validOut(residualValid)
  );

  adsDatapath #(
    .NUM_RANKS(NUM_RANKS), .FIELD_W(FIELD_W), .MAX_CYC(MAX_CYC),
    .TICKS_PER_CYC(TICKS_PER_CYC), .OFFSET_W(OFFSET_W), .RESID_W(RESID_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .targetOffset(targetOffset),
    .delayWord(delayWord), .residual(residual)
  );
endmodule

// File: tb/addDelaySplitter_tb_top.sv
module addDelaySplitter_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic loadStrobe = 1'b0;
  logic [1:0] rankSel = '0;
  logic signed [7:0] targetOffset = '0;
  logic [7:0] delayWord;
  logic signed [15:0] residual;
  logic residualValid;

  int checks = 0;
  int fails = 0;
  logic [7:0] expWord = '0;
  logic signed [15:0] expResid = '0;

  always #10 clk = ~clk;

  addDelaySplitter dut_i (
    .clk(clk), .rstN(rstN), .loadStrobe(loadStrobe), .rankSel(rankSel),
    .targetOffset(targetOffset), .delayWord(delayWord), .residual(residual),
    .residualValid(residualValid)
  );

  function automatic logic [1:0] fieldOf(int t);
    if (t > 2) return 2'd2;
    if (t < 0) return 2'd0;
    return 2'(t);
  endfunction

  function automatic int residOf(int t);
    if (t > 2) return 128 * (t - 2);
    if (t < 0) return 128 * t;
    return 0;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // strobe for one cycle, then check at the following negedge
  task automatic split(string req, int rank, int t);
    @(negedge clk);
    loadStrobe = 1'b1; rankSel = 2'(rank); targetOffset = 8'(t);
    expWord[rank*2 +: 2] = fieldOf(t);
    expResid = 16'(residOf(t));
    @(negedge clk);
    loadStrobe = 1'b0;
    check({req, " word"}, int'(delayWord), int'(expWord));
    check({req, " residual"}, int'(residual), int'(expResid));
    check({req, " valid R6"}, int'(residualValid), 1);
  endtask

  task automatic testReset();
    check("R1 word", int'(delayWord), 0);
    check("R1 residual", int'(residual), 0);
    check("R1 valid", int'(residualValid), 0);
  endtask

  task automatic testInRange();
    split("R2 t=0 r0", 0, 0);
    split("R2 t=1 r1", 1, 1);
    split("R2 t=2 r2", 2, 2);
  endtask

  task automatic testOver();
    split("R3 t=3 r3", 3, 3);
    split("R3 t=9 r0", 0, 9);
    check("R3 slot0 not 3", int'(delayWord[1:0] == 2'd3), 0);
  endtask

  task automatic testNeg();
    split("R4 t=-1 r1", 1, -1);
    split("R4 t=-5 r2", 2, -5);
  endtask

  task automatic testIsolation();
    split("R5 r3 t=1", 3, 1);
    split("R5 r0 t=2", 0, 2);
    check("R5 slot1 kept", int'(delayWord[3:2]), int'(expWord[3:2]));
    check("R5 slot2 kept", int'(delayWord[5:4]), int'(expWord[5:4]));
  endtask

  task automatic testHold();
    @(negedge clk);
    rankSel = 2'd1; targetOffset = 8'sd100;
    @(negedge clk);
    rankSel = 2'd2; targetOffset = -8'sd50;
    @(negedge clk);
    check("R7 word held", int'(delayWord), int'(expWord));
    check("R7 residual held", int'(residual), int'(expResid));
    check("R7 valid low", int'(residualValid), 0);
  endtask

  task automatic testExtremes();
    split("R8 t=-128", 2, -128);
    check("R8 residual -16384", int'(residual), -16384);
    split("R8 t=127", 1, 127);
    check("R8 residual 16000", int'(residual), 16000);
    @(negedge clk);
    check("R6 valid one cycle", int'(residualValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testInRange();
    testOver();
    testNeg();
    testIsolation();
    testHold();
    testExtremes();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule